// File: doc/BRIEF.md
# Block Transfer and Search Engine

This block runs repeated memory operations on its own once it is started. In copy mode it reads an element at the source pointer, writes the same element at the destination pointer, and repeats this until the 16-bit element counter reaches zero. In search mode it reads one byte at a time from the source pointer and compares it with a key byte. It stops when the counter runs out or when a byte equals the key, whichever happens first.

A start pulse loads the pointers, the counter, the key and the options. The options are direction, element size, and address width: in native width only the low 16 bits of a pointer move, and in extended width all 32 bits move. The engine talks to a simple synchronous memory port and holds each request until the memory answers with a one-cycle ready. When it finishes, it gives a done pulse and presents the final pointer and counter values. It also reports whether a search hit the key and whether the start was rejected because a pointer was misaligned.

Top module: `bts_engine`

## Requirements
- R1: In copy mode (`cmd_search`=0) each element is read at `src_ptr`, and the same value is then written at `dst_ptr`. Elements are processed one after another until `count` reaches zero.
- R2: `cmd_size` selects the element size: 0 is one byte, 1 is two bytes, and 2 or 3 is four bytes. `mem_size` carries the code 0, 1 or 2. Data is little-endian in the low bits of `mem_rdata`/`mem_wdata`. Both pointers move by the element size.
- R3: With `cmd_down`=0 the pointers increase after each access. With `cmd_down`=1 they decrease.
- R4: With `cmd_wide`=0 only the low 16 bits of a pointer are updated, they wrap modulo 2^16, and the upper 16 bits are held. With `cmd_wide`=1 the full 32 bits are updated.
- R5: `count` is 16 bits wide and drops by exactly one per completed element. A start with a count of zero runs as 65536 elements.
- R6: In search mode each read is one byte at `src_ptr` (`mem_size`=0, step of one), whatever the value of `cmd_size`. The run ends after the first byte equal to `init_key` or when `count` reaches zero. `match` is set only when a byte equaled the key.
- R7: `match` keeps its value after the run ends and is cleared by the next accepted start.
- R8: A copy start whose element size is two bytes with an odd pointer, or four bytes with a pointer whose two low bits are not 00, sets `err`. No memory request is issued, and the loaded pointers and count stay unchanged.
- R9: `busy` is high from the cycle after an accepted start until the run ends. `done` is high for exactly one cycle at the end of every run, including a rejected one.
- R10: A start pulse while `busy` is high is ignored and does not alter the running operation or its results.
- R11: Once `mem_req` is raised, it stays high with the same address, write flag and data until a cycle with `mem_ready` high completes the access.
- R12: After reset, `busy`, `done`, `match`, `err` and `mem_req` are low, and the pointers and count are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| cmd_search | input | 1 | 0 = copy, 1 = search |
| cmd_down | input | 1 | 0 = increment pointers, 1 = decrement |
| cmd_size | input | 2 | Element size code |
| cmd_wide | input | 1 | 0 = 16-bit pointer wrap, 1 = 32-bit |
| init_src | input | AW | Initial source pointer |
| init_dst | input | AW | Initial destination pointer |
| init_cnt | input | CW | Initial element count |
| init_key | input | 8 | Search key byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size | output | 2 | Access size code |
| mem_addr | output | AW | Access address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes in this cycle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| match | output | 1 | Search found the key |
| err | output | 1 | Start rejected for misalignment |
| src_ptr | output | AW | Current source pointer |
| dst_ptr | output | AW | Current destination pointer |
| count | output | CW | Current element count |

## Verification
The bench builds the engine with its default values: 32-bit pointers, a 16-bit native window and a 16-bit counter. With these values the 16-bit wrap can be reached by starting a pointer a few bytes below 0xFFFF. The 32-bit carry past that boundary is reached by the same start with extended width. The zero-count case, which means 65536 elements, is reached quickly through a search that starts with a count of zero and hits on its third byte, leaving 0xFFFD. The memory answers on every other cycle, so every request is seen waiting at least one cycle before it completes.

// File: rtl/bts_pkg.sv
package bts_pkg;

  localparam int BTS_DW = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_FIN  = 2'd3
  } bts_state_e;

  // normalised access size: 0 byte, 1 two bytes, 2 four bytes
  function automatic logic [1:0] size_code(input logic [1:0] raw);
    return raw[1] ? 2'd2 : raw;
  endfunction

  function automatic logic [2:0] elem_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [BTS_DW-1:0] lane_mask(input logic [1:0] code);
    case (code)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/bts_ptr_step.sv
module bts_ptr_step #(
  parameter int AW = 32,
  parameter int NW = 16
) (
  input  logic [AW-1:0] ptr,
  input  logic          dec,
  input  logic          wide,
  input  logic [2:0]    step,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] delta;
  logic [AW-1:0] full;

  always_comb begin
    delta = {{(AW-3){1'b0}}, step};
    full  = dec ? (ptr - delta) : (ptr + delta);
    nxt   = wide ? full : {ptr[AW-1:NW], full[NW-1:0]};
  end
endmodule

// File: rtl/bts_align_chk.sv
module bts_align_chk #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] ptr,
  input  logic [1:0]    code,
  output logic          ok
);
  always_comb begin
    case (code)
      2'd0:    ok = 1'b1;
      2'd1:    ok = ~ptr[0];
      default: ok = (ptr[1:0] == 2'b00);
    endcase
  end
endmodule

// File: rtl/bts_ctrl.sv
module bts_ctrl
  import bts_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       bad_start,
  input  logic       is_search,
  input  logic       mem_ready,
  input  logic       hit,
  input  logic       last,
  output bts_state_e state,
  output logic       accept,
  output logic       rd_fire,
  output logic       wr_fire
);
  bts_state_e state_d;

  always_comb begin
    accept  = (state == ST_IDLE) && start;
    rd_fire = (state == ST_RD) && mem_ready;
    wr_fire = (state == ST_WR) && mem_ready;
    state_d = state;
    case (state)
      ST_IDLE: if (accept) state_d = bad_start ? ST_FIN : ST_RD;
      ST_RD: begin
        if (rd_fire) begin
          if (is_search) state_d = (hit || last) ? ST_FIN : ST_RD;
          else           state_d = ST_WR;
        end
      end
      ST_WR:   if (wr_fire) state_d = last ? ST_FIN : ST_RD;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end
endmodule

// File: rtl/bts_engine.sv
module bts_engine
  import bts_pkg::*;
#(
  parameter int AW = 32,
  parameter int NW = 16,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cmd_search,
  input  logic              cmd_down,
  input  logic [1:0]        cmd_size,
  input  logic              cmd_wide,
  input  logic [AW-1:0]     init_src,
  input  logic [AW-1:0]     init_dst,
  input  logic [CW-1:0]     init_cnt,
  input  logic [7:0]        init_key,
  output logic              mem_req,
  output logic              mem_we,
  output logic [1:0]        mem_size,
  output logic [AW-1:0]     mem_addr,
  output logic [BTS_DW-1:0] mem_wdata,
  input  logic [BTS_DW-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              busy,
  output logic              done,
  output logic              match,
  output logic              err,
  output logic [AW-1:0]     src_ptr,
  output logic [AW-1:0]     dst_ptr,
  output logic [CW-1:0]     count
);
  localparam int NPTR = 2;

  bts_state_e state;
  logic accept, rd_fire, wr_fire;

  logic [AW-1:0]     hl_q, de_q;
  logic [CW-1:0]     bc_q;
  logic [7:0]        key_q;
  logic              search_q, down_q, wide_q;
  logic [1:0]        sz_q;
  logic [BTS_DW-1:0] buf_q;
  logic              match_q, err_q;

  logic [1:0]               cmd_code;
  logic [NPTR-1:0]          ok_v;
  logic                     bad_start;
  logic [2:0]               step_w;
  logic [NPTR-1:0][AW-1:0]  nxt_v;
  logic [CW-1:0]            bc_dec;
  logic                     last, hit;
  logic                     elem_done;  // event for the checker

  assign cmd_code  = size_code(cmd_size);
  assign bad_start = !cmd_search && !(&ok_v);
  assign step_w    = search_q ? 3'd1 : elem_bytes(sz_q);
  assign bc_dec    = bc_q - {{(CW-1){1'b0}}, 1'b1};
  assign last      = (bc_dec == '0);
  assign hit       = (mem_rdata[7:0] == key_q);
  assign elem_done = (rd_fire && search_q) || wr_fire;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    bts_align_chk #(.AW(AW)) u_align (
      .ptr  (g == 0 ? init_src : init_dst),
      .code (cmd_code),
      .ok   (ok_v[g])
    );
    bts_ptr_step #(.AW(AW), .NW(NW)) u_step (
      .ptr  (g == 0 ? hl_q : de_q),
      .dec  (down_q),
      .wide (wide_q),
      .step (step_w),
      .nxt  (nxt_v[g])
    );
  end

  bts_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .bad_start (bad_start),
    .is_search (search_q),
    .mem_ready (mem_ready),
    .hit       (hit),
    .last      (last),
    .state     (state),
    .accept    (accept),
    .rd_fire   (rd_fire),
    .wr_fire   (wr_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hl_q     <= '0;
      de_q     <= '0;
      bc_q     <= '0;
      key_q    <= '0;
      search_q <= 1'b0;
      down_q   <= 1'b0;
      wide_q   <= 1'b0;
      sz_q     <= 2'd0;
      buf_q    <= '0;
      match_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (accept) begin
        hl_q     <= init_src;
        de_q     <= init_dst;
        bc_q     <= init_cnt;
        key_q    <= init_key;
        search_q <= cmd_search;
        down_q   <= cmd_down;
        wide_q   <= cmd_wide;
        sz_q     <= cmd_code;
        match_q  <= 1'b0;
        err_q    <= bad_start;
      end
      if (rd_fire) begin
        hl_q <= nxt_v[0];
        if (search_q) begin
          bc_q <= bc_dec;
          if (hit) match_q <= 1'b1;
        end else begin
          buf_q <= mem_rdata;
        end
      end
      if (wr_fire) begin
        de_q <= nxt_v[1];
        bc_q <= bc_dec;
      end
    end
  end

  assign mem_req   = (state == ST_RD) || (state == ST_WR);
  assign mem_we    = (state == ST_WR);
  assign mem_addr  = (state == ST_WR) ? de_q : hl_q;
  assign mem_size  = search_q ? 2'd0 : sz_q;
  assign mem_wdata = buf_q & lane_mask(sz_q);
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FIN);
  assign match     = match_q;
  assign err       = err_q;
  assign src_ptr   = hl_q;
  assign dst_ptr   = de_q;
  assign count     = bc_q;
endmodule

// File: rtl/bts_checker.sv
module bts_checker #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          match,
  input logic          err,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ready,
  input logic [1:0]    mem_size,
  input logic [AW-1:0] mem_addr,
  input logic [CW-1:0] count,
  input logic          elem_done,
  input logic          search_q
);
  // R11: a waiting request keeps its address and direction
  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R9: done lasts a single cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: a rejected start never touches memory
  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !mem_req);

  // R7: match only clears through an accepted start
  a_r7_match_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !(start && !busy)) |=> match);

  // R5: counter falls by exactly one per finished element
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    elem_done |=> (count == CW'($past(count) - 1'b1)));

  // R6: searches always use byte accesses
  a_r6_search_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && search_q) |-> (mem_size == 2'd0));
endmodule

bind bts_engine bts_checker #(.AW(AW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .match     (match),
  .err       (err),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ready (mem_ready),
  .mem_size  (mem_size),
  .mem_addr  (mem_addr),
  .count     (count),
  .elem_done (elem_done),
  .search_q  (search_q)
);

// File: tb/tb_bts_engine.sv
`timescale 1ns/1ps
module tb_bts_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cmd_search = 1'b0, cmd_down = 1'b0, cmd_wide = 1'b0;
  logic [1:0]  cmd_size = 2'd0;
  logic [31:0] init_src = '0, init_dst = '0;
  logic [15:0] init_cnt = '0;
  logic [7:0]  init_key = '0;
  logic        mem_req, mem_we;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;
  logic        busy, done, match, err;
  logic [31:0] src_ptr, dst_ptr;
  logic [15:0] count;

  int vectors = 0;
  int fails = 0;

  always #2 clk = ~clk;

  bts_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_search(cmd_search),
    .cmd_down(cmd_down), .cmd_size(cmd_size), .cmd_wide(cmd_wide),
    .init_src(init_src), .init_dst(init_dst), .init_cnt(init_cnt),
    .init_key(init_key), .mem_req(mem_req), .mem_we(mem_we),
    .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .busy(busy), .done(done),
    .match(match), .err(err), .src_ptr(src_ptr), .dst_ptr(dst_ptr),
    .count(count)
  );

  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
    logic [1:0]  sz;
  } txn_t;

  txn_t        expq[$];
  logic [7:0]  mem  [logic [31:0]];
  logic [7:0]  mmod [logic [31:0]];
  logic [31:0] exp_hl, exp_de;
  logic [15:0] exp_bc;
  logic        exp_match, exp_err;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rdb(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  function automatic logic [7:0] rdm(input logic [31:0] a);
    return mmod.exists(a) ? mmod[a] : 8'h00;
  endfunction

  function automatic logic [31:0] adv(input logic [31:0] p, input logic dn,
                                     input logic wd, input int n);
    logic [31:0] f;
    logic [15:0] lo;
    if (wd) begin
      f = dn ? p - 32'(n) : p + 32'(n);
      return f;
    end
    lo = dn ? p[15:0] - 16'(n) : p[15:0] + 16'(n);
    return {p[31:16], lo};
  endfunction

  // memory responder: ready every other cycle, checks each access
  always @(negedge clk) begin : mem_side
    txn_t t;
    int   nb;
    logic [31:0] v;
    if (!rst_n) begin
      mem_ready = 1'b0;
    end else if (mem_req && !mem_ready) begin
      mem_ready = 1'b1;
      nb = (mem_size == 2'd0) ? 1 : (mem_size == 2'd1) ? 2 : 4;
      if (expq.size() == 0) begin
        chk("R1", "unexpected access", 32'd1, 32'd0);
      end else begin
        t = expq.pop_front();
        chk("R1", "access direction", {31'd0, mem_we}, {31'd0, t.we});
        chk("R3", "access address", mem_addr, t.addr);
        chk("R2", "access size", {30'd0, mem_size}, {30'd0, t.sz});
      end
      if (mem_we) begin
        v = mem_wdata;
        if (t.we) chk("R1", "write data", v, t.data);
        for (int i = 0; i < nb; i++) mem[mem_addr + 32'(i)] = v[8*i +: 8];
      end else begin
        v = '0;
        for (int i = 0; i < nb; i++) v[8*i +: 8] = rdb(mem_addr + 32'(i));
        mem_rdata = v;
      end
    end else begin
      mem_ready = 1'b0;
    end
  end

  task automatic model(input logic srch, input logic dn, input logic [1:0] sz,
                       input logic wd, input logic [31:0] hl, input logic [31:0] de,
                       input logic [15:0] bc, input logic [7:0] key);
    int   esz;
    int   n;
    logic [1:0] code;
    logic [31:0] v;
    txn_t t;
    mmod = mem;
    code = sz[1] ? 2'd2 : sz;
    esz  = srch ? 1 : (code == 2'd0 ? 1 : (code == 2'd1 ? 2 : 4));
    exp_match = 1'b0;
    exp_err   = 1'b0;
    if (!srch && ((hl % esz) != 0 || (de % esz) != 0)) begin
      exp_err = 1'b1;
      exp_hl = hl; exp_de = de; exp_bc = bc;
      return;
    end
    n = (bc == 16'd0) ? 65536 : int'(bc);
    for (int k = 0; k < n; k++) begin
      v = '0;
      for (int i = 0; i < esz; i++) v[8*i +: 8] = rdm(hl + 32'(i));
      t.we = 1'b0; t.addr = hl; t.data = v; t.sz = srch ? 2'd0 : code;
      expq.push_back(t);
      hl = adv(hl, dn, wd, esz);
      bc = bc - 16'd1;
      if (srch) begin
        if (v[7:0] == key) begin
          exp_match = 1'b1;
          break;
        end
      end else begin
        t.we = 1'b1; t.addr = de;
        expq.push_back(t);
        for (int i = 0; i < esz; i++) mmod[de + 32'(i)] = v[8*i +: 8];
        de = adv(de, dn, wd, esz);
      end
    end
    exp_hl = hl; exp_de = de; exp_bc = bc;
  endtask

  task automatic run(input string tag, input logic srch, input logic dn,
                     input logic [1:0] sz, input logic wd, input logic [31:0] hl,
                     input logic [31:0] de, input logic [15:0] bc,
                     input logic [7:0] key, input bit poke);
    int k;
    model(srch, dn, sz, wd, hl, de, bc, key);
    @(negedge clk);
    cmd_search = srch; cmd_down = dn; cmd_size = sz; cmd_wide = wd;
    init_src = hl; init_dst = de; init_cnt = bc; init_key = key;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9", "busy after start", {31'd0, busy}, 32'd1);
    chk("R7", "match cleared by start", {31'd0, match}, 32'd0);
    k = 0;
    while (!done && k < 5000) begin
      @(negedge clk);
      k++;
      if (poke && k == 3) begin
        // R10: a second start while running must have no effect
        init_src = 32'hDEAD_0000; init_dst = 32'h0BAD_0000; init_cnt = 16'd1;
        cmd_search = ~srch; start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    chk("R9", {tag, " done seen"}, {31'd0, done}, 32'd1);
    chk("R4", {tag, " source ptr"}, src_ptr, exp_hl);
    chk("R4", {tag, " dest ptr"}, dst_ptr, exp_de);
    chk("R5", {tag, " count"}, {16'd0, count}, {16'd0, exp_bc});
    chk("R6", {tag, " match"}, {31'd0, match}, {31'd0, exp_match});
    chk("R8", {tag, " err"}, {31'd0, err}, {31'd0, exp_err});
    chk("R1", {tag, " all accesses made"}, 32'(expq.size()), 32'd0);
    expq.delete();
    @(negedge clk);
    chk("R9", {tag, " done one cycle"}, {31'd0, done}, 32'd0);
    chk("R9", {tag, " idle after done"}, {31'd0, busy}, 32'd0);
  endtask

  task automatic fill(input logic [31:0] base, input int n);
    for (int i = 0; i < n; i++) mem[base + 32'(i)] = 8'((base + 32'(i)) * 7 + 3);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", "busy", {31'd0, busy}, 32'd0);
    chk("R12", "done", {31'd0, done}, 32'd0);
    chk("R12", "match", {31'd0, match}, 32'd0);
    chk("R12", "err", {31'd0, err}, 32'd0);
    chk("R12", "mem_req", {31'd0, mem_req}, 32'd0);
    chk("R12", "count", {16'd0, count}, 32'd0);
    chk("R12", "src", src_ptr, 32'd0);
    rst_n = 1'b1;
    fill(32'h100, 8); fill(32'h1000, 16); fill(32'h1100, 8);
    fill(32'hFFFE, 2); fill(32'h0, 4); fill(32'h1_0000, 8);
    fill(32'h300, 32); fill(32'h200, 4); fill(32'h400, 8);
    // R1 R3 R10: byte copy upward, native width, with a start while busy
    run("byte-copy", 1'b0, 1'b0, 2'd0, 1'b0, 32'h100, 32'h180, 16'd5, 8'h00, 1'b1);
    // R2 R3: two-byte copy downward, extended width
    run("word-down", 1'b0, 1'b1, 2'd1, 1'b1, 32'h1106, 32'h2206, 16'd3, 8'h00, 1'b0);
    // R2: four-byte copy upward (size code 3 counts as four bytes)
    run("long-copy", 1'b0, 1'b0, 2'd3, 1'b1, 32'h1000, 32'h2000, 16'd4, 8'h00, 1'b0);
    // R4: 16-bit wrap in native width
    run("native-wrap", 1'b0, 1'b0, 2'd0, 1'b0, 32'hFFFE, 32'hFFFD, 16'd4, 8'h00, 1'b0);
    // R4: carry past bit 15 in extended width
    run("wide-carry", 1'b0, 1'b0, 2'd1, 1'b1, 32'hFFFE, 32'h3000, 16'd3, 8'h00, 1'b0);
    // R8: misaligned two-byte copy is rejected
    run("misaligned", 1'b0, 1'b0, 2'd1, 1'b0, 32'h501, 32'h600, 16'd4, 8'h00, 1'b0);
    // R8: four-byte copy with destination low bits 10 is rejected
    run("misaligned-dst", 1'b0, 1'b0, 2'd2, 1'b1, 32'h1000, 32'h2002, 16'd2, 8'h00, 1'b0);
    // R6: search downward, key at fourth byte
    run("search-hit", 1'b1, 1'b1, 2'd0, 1'b0, 32'h310, 32'h0, 16'd10, rdb(32'h30D), 1'b0);
    // R7: match held after the run
    repeat (5) @(negedge clk);
    chk("R7", "match held", {31'd0, match}, 32'd1);
    // R6: search that exhausts the count
    for (int i = 0; i < 6; i++) mem[32'h700 + 32'(i)] = 8'h11;
    run("search-miss", 1'b1, 1'b0, 2'd0, 1'b0, 32'h700, 32'h0, 16'd6, 8'h22, 1'b0);
    // R5: zero count means 65536, hit on third byte leaves FFFD
    run("search-zero", 1'b1, 1'b0, 2'd0, 1'b0, 32'h200, 32'h0, 16'd0, rdb(32'h202), 1'b0);
    // R6: size code ignored by search, odd start allowed
    run("search-size", 1'b1, 1'b0, 2'd2, 1'b1, 32'h401, 32'h0, 16'd3, 8'hFF, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule